// File: doc/BRIEF.md
# Two-Stage Prescaled Baud Tick Generator

This block produces the timing reference for a serial transceiver. Two down-counters are chained. The first divides the system clock by a small prescale setting. The second divides that enable by an 11-bit divisor setting. The result is a one-cycle `tick` that a receiver and transmitter use to time their shifting.

In asynchronous mode the tick is the 16x oversampling strobe. The fastest bit rate is then the system clock divided by 16. In synchronous mode the same tick toggles `bit_clk`, a square serial clock whose fastest rate is the system clock divided by 2.

A field value of N divides its stage by N+1. Any change to the prescale value, the divisor value or the mode restarts both counters, so the new rate begins with a complete period.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `tick` and `bit_clk` are 0. The exception is that `tick` may rise at the first edge after reset when both settings are already 0.
- R2: With prescale value P and divisor value D held steady, `tick` pulses once every N = (P+1)*(D+1) clock cycles. The first pulse is high in the cycle after the (N+1)-th rising edge that follows the cycle in which the settings changed.
- R3: Each `tick` pulse is exactly one clock cycle wide whenever N is greater than 1.
- R4: With P = 0 and D = 0 neither stage divides, so `tick` is high in every cycle from the second edge after the change onward.
- R5: A change of `pre_val`, `div_val` or `sync_mode` restarts both counters. No pulse from the old setting follows, and the first new pulse comes a full N+1 edges after the change.
- R6: In synchronous mode (`sync_mode` = 1), `bit_clk` is cleared on a settings change and then toggles at the same edge on which each `tick` rises. Its period is therefore 2N cycles, and 2 cycles at the fastest setting.
- R7: In asynchronous mode (`sync_mode` = 0), `bit_clk` stays 0 and `tick` is the 16x oversampling strobe.
- R8: The prescale field is 4 bits wide (16 settings) and the divisor field is 11 bits wide (2048 settings). At P = 15 and D = 2047 the tick period is 32768 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sync_mode | input | 1 | 1 selects synchronous mode, 0 selects asynchronous mode |
| pre_val | input | PRE_W (4) | First-stage setting; the stage divides by value+1 |
| div_val | input | DIV_W (11) | Second-stage setting; the stage divides by value+1 |
| tick | output | 1 | One-cycle rate strobe |
| bit_clk | output | 1 | Toggled serial clock in synchronous mode; 0 in asynchronous mode |

## Verification
Settings are driven just after a rising edge. The design registers the change at the next edge, counted as edge 1. Every output is registered, so the first pulse is visible after edge N+1 and each later pulse N edges after the previous one. `bit_clk` changes at the same edges as `tick` rises. Each scenario task samples both outputs at the falling edge after every rising edge and compares them with values it computes from P, D and the edge count alone. That includes an early reprogramming in the middle of a period and a change of mode alone.

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
  parameter int PRE_W = 4,
  parameter int DIV_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_mode,
  input  logic [PRE_W-1:0] pre_val,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick,
  output logic             bit_clk
);
  localparam int GAP_W = PRE_W + DIV_W + 1;

  logic [PRE_W-1:0] pre_q, pcnt;
  logic [DIV_W-1:0] div_q, dcnt;
  logic             mode_q;

  wire chg     = (pre_val != pre_q) || (div_val != div_q) || (sync_mode != mode_q);
  wire pre_end = (pcnt == '0);
  wire div_end = (dcnt == '0);
  wire pre_en  = pre_end && !chg;
  wire fire    = pre_en && div_end;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_q   <= '0;
      div_q   <= '0;
      mode_q  <= 1'b0;
      pcnt    <= '0;
      dcnt    <= '0;
      tick    <= 1'b0;
      bit_clk <= 1'b0;
    end else begin
      pre_q  <= pre_val;
      div_q  <= div_val;
      mode_q <= sync_mode;
      tick   <= fire;
      if (chg) begin
        pcnt    <= pre_val;
        dcnt    <= div_val;
        bit_clk <= 1'b0;
      end else begin
        pcnt <= pre_end ? pre_q : pcnt - 1'b1;
        if (pre_en) dcnt <= div_end ? div_q : dcnt - 1'b1;
        if (fire && mode_q) bit_clk <= ~bit_clk;
      end
    end
  end

  // checking only: cycles since the last pulse or restart
  logic [GAP_W-1:0] gap;
  wire  [GAP_W-1:0] period_w = (GAP_W'(pre_q) + GAP_W'(1)) * (GAP_W'(div_q) + GAP_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)            gap <= '0;
    else if (chg || fire)  gap <= '0;
    else                   gap <= gap + 1'b1;
  end

  assert_gap_within_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    gap < period_w);

  assert_single_cycle_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && period_w != GAP_W'(1)) |=> !tick);

  assert_restart_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    chg |=> !tick);

  assert_bitclk_moves_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bit_clk) |-> (tick || $past(chg)));

  assert_async_bitclk_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> !bit_clk);
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_mode = 1'b0;
  logic [3:0]  pre_val = '0;
  logic [10:0] div_val = '0;
  logic        tick, bit_clk;

  int checks = 0;
  int fails  = 0;

  baud_tick_gen dut (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode),
    .pre_val(pre_val), .div_val(div_val),
    .tick(tick), .bit_clk(bit_clk)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive a setting just after an edge, then compare M edges of output.
  task automatic run_cfg(input string req, input int p, input int d, input logic sm, input int m);
    int n = (p + 1) * (d + 1);
    @(posedge clk);
    #1;
    pre_val   = 4'(p);
    div_val   = 11'(d);
    sync_mode = sm;
    for (int k = 1; k <= m; k++) begin
      int  t;
      logic et, eb;
      @(posedge clk);
      @(negedge clk);
      et = (k >= n + 1) && ((k - 1) % n == 0);
      t  = (k >= n + 1) ? (k - 1) / n : 0;
      eb = sm ? t[0] : 1'b0;
      check(req, $sformatf("tick P=%0d D=%0d k=%0d", p, d, k), tick, et);
      check(req, $sformatf("bit_clk P=%0d D=%0d k=%0d", p, d, k), bit_clk, eb);
    end
  endtask

  task automatic test_reset();
    repeat (3) begin
      @(negedge clk);
      check("R1", "tick in reset", tick, 1'b0);
      check("R1", "bit_clk in reset", bit_clk, 1'b0);
    end
    rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", "bit_clk after reset", bit_clk, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    run_cfg("R4", 0, 0, 1'b1, 8);       // undivided, sync: clk/2 bit clock (R6)
    run_cfg("R4", 0, 0, 1'b0, 8);       // undivided, async (R7)
    run_cfg("R2", 2, 0, 1'b0, 12);      // prescaler only, N=3
    run_cfg("R2", 0, 4, 1'b0, 16);      // divisor only, N=5
    run_cfg("R6", 3, 4, 1'b1, 12);      // interrupted mid-period
    run_cfg("R5", 1, 2, 1'b1, 20);      // reload takes full new period
    run_cfg("R7", 1, 2, 1'b0, 20);      // mode-only change restarts
    run_cfg("R3", 2, 1, 1'b1, 30);      // N=6 pulse width and toggling
    run_cfg("R6", 15, 3, 1'b1, 200);    // N=64 sync
    run_cfg("R8", 15, 2047, 1'b0, 32770);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule